// File: doc/BRIEF.md
# Warp Issue Scheduler

The scheduler keeps a pool of resident warps and, each time its issue slot becomes free, selects one warp to send to the execution lanes. A thread block enters through a launch port that carries the block's identifier and its thread count. The block is divided into warps of a fixed width and placed into free warp slots. If the thread count does not fill the last warp, that warp gets a lane mask that enables only the threads that exist. A launch is held off when the block does not fit.

External operand-tracking logic supplies one ready bit per warp slot. A slot is eligible when it holds a warp and its ready bit is high. The eligible slot with the lowest index wins. An issued instruction keeps the slot busy for a fixed dispatch window while it goes out over the warp's lanes. The next issue follows immediately after that window, so changing from one warp to another costs no cycle.

Each warp keeps its own instruction index, and the issue output reports that index. A warp-complete input releases a slot. A block leaves the pool when its last warp completes.

Top module: `warp_issue_sched`

## Requirements
- R1: An accepted block of T threads (1 to 512) occupies ceil(T/32) warp slots. These are the lowest-indexed free slots, filled in ascending order, with the block's first warp in the lowest of them.
- R2: Every warp of a block except the last has a 32-bit lane mask of all ones. The last warp has all ones when T is a multiple of 32. Otherwise only bits 0 to (T mod 32)-1 are set. The mask is reported on `issue_lanes`, with bit i standing for lane i.
- R3: `launch_ready` is low when any of these holds: T is 0, T exceeds 512, fewer free slots remain than the block needs, or 8 blocks are resident. A launch offered while `launch_ready` is low changes nothing.
- R4: A warp is issued only if its slot is occupied and its `warp_ready` bit is high in the selection cycle, which is the cycle before `issue_valid` rises. When no slot is eligible, `issue_valid` stays low.
- R5: When several slots are eligible, the one with the lowest index is issued.
- R6: `issue_valid` is high for one cycle per instruction. The next issue comes no sooner than 4 cycles later. Eligibility changes during those 4 cycles have no effect until the window closes.
- R7: When the window closes and some slot is eligible, the next issue comes exactly 4 cycles after the previous one, even when the new warp differs from the previous one.
- R8: A warp's instruction index is 0 at launch and rises by one with each of its issues, independently of the other warps. `issue_blk` carries the identifier of the warp's block.
- R9: `done_valid` releases slot `done_warp`. A block retires when all of its warps have completed, which frees one of the 8 block places. A completion for an empty slot is ignored.
- R10: After reset no warp or block is resident, `issue_valid` is low, and a launch of 1 to 512 threads is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Block launch request |
| launch_blk_id | input | 8 | Identifier of the launched block |
| launch_threads | input | 10 | Thread count of the launched block |
| launch_ready | output | 1 | Launch accepted in this cycle when valid |
| warp_ready | input | 24 | Per-slot operands-available bits |
| done_valid | input | 1 | Warp completion strobe |
| done_warp | input | 5 | Slot of the completing warp |
| issue_valid | output | 1 | One-cycle issue pulse |
| issue_warp | output | 5 | Slot of the issued warp |
| issue_pc | output | 8 | Instruction index of the issued warp |
| issue_lanes | output | 32 | Lane-valid mask of the issued warp |
| issue_blk | output | 8 | Block identifier of the issued warp |

## Verification
Four properties are checked on every cycle:
- every selection picks the lowest eligible slot, and that slot is eligible;
- issues are spaced at least one dispatch window apart;
- an eligible slot at the close of a window always leads to an issue on the next cycle;
- a launch never claims a slot that is already occupied, and a zero-thread launch is always refused.

Some behaviours depend on counts and on the order of events, and only the bench's scenarios show them:
- the tail lane mask and slot count for every thread count from 1 to 512;
- instruction indices that restart at launch;
- retirement of a block after its last completion;
- the eight-block limit;
- a completion sent to an empty slot having no effect.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
    localparam int unsigned DEF_WARP_SIZE   = 32;
    localparam int unsigned DEF_MAX_WARPS   = 24;
    localparam int unsigned DEF_MAX_BLOCKS  = 8;
    localparam int unsigned DEF_MAX_THREADS = 512;
    localparam int unsigned DEF_DISPATCH    = 4;

    // Index width for a set of v entries, never below one bit.
    function automatic int unsigned idx_w(input int unsigned v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction
endpackage

// File: rtl/wsched_pick.sv
module wsched_pick #(
    parameter int unsigned N = 24,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/wsched_alloc.sv
module wsched_alloc #(
    parameter int unsigned WARP_SIZE   = 32,
    parameter int unsigned MAX_WARPS   = 24,
    parameter int unsigned MAX_THREADS = 512,
    parameter int unsigned THR_W       = 10,
    parameter int unsigned CNT_W       = 5
) (
    input  logic [MAX_WARPS-1:0]                busy,
    input  logic [THR_W-1:0]                    threads,
    input  logic                                blk_avail,
    output logic                                ready,
    output logic [CNT_W-1:0]                    need,
    output logic [MAX_WARPS-1:0]                take,
    output logic [MAX_WARPS-1:0][WARP_SIZE-1:0] take_lanes
);
    localparam int unsigned LANE_W = $clog2(WARP_SIZE);

    logic [THR_W:0]     sum;
    logic [LANE_W-1:0]  rem;
    logic [WARP_SIZE-1:0] tail;
    logic [CNT_W-1:0]   free_cnt;
    logic [CNT_W-1:0]   k;

    always_comb begin
        sum  = {1'b0, threads} + (THR_W + 1)'(WARP_SIZE - 1);
        need = CNT_W'(sum >> LANE_W);
        rem  = threads[LANE_W-1:0];
        tail = (rem == '0) ? '1 : ((WARP_SIZE'(1) << rem) - WARP_SIZE'(1));

        free_cnt = '0;
        for (int i = 0; i < MAX_WARPS; i++) free_cnt = free_cnt + CNT_W'(!busy[i]);

        k          = '0;
        take       = '0;
        take_lanes = '0;
        for (int i = 0; i < MAX_WARPS; i++) begin
            if (!busy[i] && (k < need)) begin
                take[i]       = 1'b1;
                take_lanes[i] = (k == need - CNT_W'(1)) ? tail : '1;
                k             = k + CNT_W'(1);
            end
        end

        ready = blk_avail && (threads != '0) && (threads <= THR_W'(MAX_THREADS))
                && (need <= free_cnt);
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wsched_pkg::*;
#(
    parameter int unsigned WARP_SIZE    = DEF_WARP_SIZE,
    parameter int unsigned MAX_WARPS    = DEF_MAX_WARPS,
    parameter int unsigned MAX_BLOCKS   = DEF_MAX_BLOCKS,
    parameter int unsigned MAX_THREADS  = DEF_MAX_THREADS,
    parameter int unsigned DISPATCH_CYC = DEF_DISPATCH,
    parameter int unsigned PC_W         = 8,
    parameter int unsigned BLK_ID_W     = 8,
    localparam int unsigned WID_W       = idx_w(MAX_WARPS),
    localparam int unsigned THR_W       = $clog2(MAX_THREADS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    input  logic [BLK_ID_W-1:0]  launch_blk_id,
    input  logic [THR_W-1:0]     launch_threads,
    output logic                 launch_ready,
    input  logic [MAX_WARPS-1:0] warp_ready,
    input  logic                 done_valid,
    input  logic [WID_W-1:0]     done_warp,
    output logic                 issue_valid,
    output logic [WID_W-1:0]     issue_warp,
    output logic [PC_W-1:0]      issue_pc,
    output logic [WARP_SIZE-1:0] issue_lanes,
    output logic [BLK_ID_W-1:0]  issue_blk
);
    localparam int unsigned BIX_W = idx_w(MAX_BLOCKS);
    localparam int unsigned CNT_W = $clog2(MAX_WARPS + 1);
    localparam int unsigned DSP_W = idx_w(DISPATCH_CYC);
    localparam int unsigned GAP_W = $clog2(DISPATCH_CYC + 1);

    typedef struct packed {
        logic [MAX_WARPS-1:0]                 alloc;
        logic [MAX_WARPS-1:0][PC_W-1:0]       pc;
        logic [MAX_WARPS-1:0][WARP_SIZE-1:0]  lanes;
        logic [MAX_WARPS-1:0][BIX_W-1:0]      wblk;
        logic [MAX_BLOCKS-1:0]                bvalid;
        logic [MAX_BLOCKS-1:0][BLK_ID_W-1:0]  bid;
        logic [MAX_BLOCKS-1:0][CNT_W-1:0]     bleft;
        logic [DSP_W-1:0]                     disp;
        logic                                 iss_v;
        logic [WID_W-1:0]                     iss_w;
        logic [PC_W-1:0]                      iss_pc;
        logic [WARP_SIZE-1:0]                 iss_lanes;
        logic [BLK_ID_W-1:0]                  iss_blk;
    } st_t;

    st_t st_q, st_d;

    logic [MAX_WARPS-1:0]                elig;
    logic                                pick_v;
    logic [WID_W-1:0]                    pick;
    logic                                bfree_v;
    logic [BIX_W-1:0]                    bfree;
    logic [CNT_W-1:0]                    need;
    logic [MAX_WARPS-1:0]                take;
    logic [MAX_WARPS-1:0][WARP_SIZE-1:0] take_lanes;
    logic                                accept;
    logic [BIX_W-1:0]                    db;

    assign elig = st_q.alloc & warp_ready;

    wsched_pick #(.N(MAX_WARPS)) u_warp_pick (
        .req(elig), .found(pick_v), .idx(pick)
    );

    wsched_pick #(.N(MAX_BLOCKS)) u_blk_pick (
        .req(~st_q.bvalid), .found(bfree_v), .idx(bfree)
    );

    wsched_alloc #(
        .WARP_SIZE(WARP_SIZE), .MAX_WARPS(MAX_WARPS), .MAX_THREADS(MAX_THREADS),
        .THR_W(THR_W), .CNT_W(CNT_W)
    ) u_alloc (
        .busy(st_q.alloc), .threads(launch_threads), .blk_avail(bfree_v),
        .ready(launch_ready), .need(need), .take(take), .take_lanes(take_lanes)
    );

    assign accept = launch_valid && launch_ready;

    always_comb begin
        st_d       = st_q;
        st_d.iss_v = 1'b0;
        db         = '0;

        // block launch: claims free slots only
        if (accept) begin
            st_d.bvalid[bfree] = 1'b1;
            st_d.bid[bfree]    = launch_blk_id;
            st_d.bleft[bfree]  = need;
            for (int i = 0; i < MAX_WARPS; i++) begin
                if (take[i]) begin
                    st_d.alloc[i] = 1'b1;
                    st_d.pc[i]    = '0;
                    st_d.lanes[i] = take_lanes[i];
                    st_d.wblk[i]  = bfree;
                end
            end
        end

        // issue slot: dispatch window, then lowest eligible warp
        if (st_q.disp != '0) begin
            st_d.disp = st_q.disp - DSP_W'(1);
        end else if (pick_v) begin
            st_d.iss_v     = 1'b1;
            st_d.iss_w     = pick;
            st_d.iss_pc    = st_q.pc[pick];
            st_d.iss_lanes = st_q.lanes[pick];
            st_d.iss_blk   = st_q.bid[st_q.wblk[pick]];
            st_d.pc[pick]  = st_q.pc[pick] + PC_W'(1);
            st_d.disp      = DSP_W'(DISPATCH_CYC - 1);
        end

        // completion: releases an occupied slot, retires an emptied block
        if (done_valid && (done_warp < WID_W'(MAX_WARPS)) && st_q.alloc[done_warp]) begin
            db                 = st_q.wblk[done_warp];
            st_d.alloc[done_warp] = 1'b0;
            st_d.bleft[db]     = st_q.bleft[db] - CNT_W'(1);
            if (st_q.bleft[db] == CNT_W'(1)) st_d.bvalid[db] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid = st_q.iss_v;
    assign issue_warp  = st_q.iss_w;
    assign issue_pc    = st_q.iss_pc;
    assign issue_lanes = st_q.iss_lanes;
    assign issue_blk   = st_q.iss_blk;

    // cycles since the last issue, saturating at the window length
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(DISPATCH_CYC);
        end else if (issue_valid) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q < GAP_W'(DISPATCH_CYC)) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    AST_PICK_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        pick_v |-> (st_q.alloc[pick] && warp_ready[pick])); // R4

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pick_v |-> ((elig & ((MAX_WARPS'(1) << pick) - MAX_WARPS'(1))) == '0)); // R5

    AST_DISPATCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (gap_q >= GAP_W'(DISPATCH_CYC))); // R6

    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.disp == '0) && (elig != '0)) |=> issue_valid); // R7

    AST_ALLOC_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ((take & st_q.alloc) == '0)); // R1

    AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_threads == '0) |-> !launch_ready); // R3
endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_valid = 1'b0;
    logic [7:0]  launch_blk_id = '0;
    logic [9:0]  launch_threads = '0;
    logic        launch_ready;
    logic [23:0] warp_ready = '0;
    logic        done_valid = 1'b0;
    logic [4:0]  done_warp = '0;
    logic        issue_valid;
    logic [4:0]  issue_warp;
    logic [7:0]  issue_pc;
    logic [31:0] issue_lanes;
    logic [7:0]  issue_blk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    warp_issue_sched u0 (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_blk_id(launch_blk_id),
        .launch_threads(launch_threads), .launch_ready(launch_ready),
        .warp_ready(warp_ready), .done_valid(done_valid), .done_warp(done_warp),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_pc(issue_pc),
        .issue_lanes(issue_lanes), .issue_blk(issue_blk)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // offer a block; returns whether it was ready
    task automatic launch(input logic [7:0] id, input int t, output bit rdy);
        @(negedge clk);
        launch_valid   = 1'b1;
        launch_blk_id  = id;
        launch_threads = 10'(t);
        #1 rdy = launch_ready;
        @(negedge clk);
        launch_valid = 1'b0;
    endtask

    task automatic complete(input int w);
        @(negedge clk);
        done_valid = 1'b1;
        done_warp  = 5'(w);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic wait_issue(input int maxc, output bit got, output int at);
        got = 1'b0;
        at  = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (issue_valid) begin
                got = 1'b1;
                at  = cyc;
                break;
            end
        end
    endtask

    function automatic logic [31:0] tail_of(input int t);
        return (t % 32 == 0) ? 32'hFFFF_FFFF : ((32'd1 << (t % 32)) - 32'd1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDG", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        bit rdy, got;
        int at, last_at, n;

        do_reset();
        @(negedge clk);
        chk(issue_valid == 1'b0, "R10", "issue_valid after reset", issue_valid, 0);
        launch_threads = 10'd32;
        #1 chk(launch_ready == 1'b1, "R10", "ready after reset", launch_ready, 1);

        launch(8'h01, 0, rdy);
        chk(rdy == 1'b0, "R3", "zero threads refused", rdy, 0);
        launch(8'h01, 513, rdy);
        chk(rdy == 1'b0, "R3", "513 threads refused", rdy, 0);

        // sweep every legal thread count: slot count, tail mask, index reset, retire
        for (int t = 1; t <= 512; t++) begin
            n = (t + 31) / 32;
            warp_ready = '0;
            launch(8'(t), t, rdy);
            chk(rdy == 1'b1, "R1", "sweep launch ready", rdy, 1);
            warp_ready = 24'd1 << (n - 1);
            wait_issue(8, got, at);
            chk(got && issue_warp == 5'(n - 1), "R1", "last warp slot", issue_warp, n - 1);
            chk(issue_lanes == tail_of(t), "R2", "tail lane mask", issue_lanes, tail_of(t));
            chk(issue_pc == 8'd0 && issue_blk == 8'(t), "R8", "fresh index/block id",
                {issue_pc, issue_blk}, {8'd0, 8'(t)});
            warp_ready = '0;
            repeat (4) @(negedge clk);
            for (int w = 0; w < n; w++) complete(w);
        end

        // priority, spacing and per-warp index with three resident warps
        launch(8'h11, 96, rdy);
        chk(rdy == 1'b1, "R1", "96-thread launch", rdy, 1);
        warp_ready = 24'h7;
        last_at = 0;
        for (int i = 0; i < 6; i++) begin
            wait_issue(8, got, at);
            chk(got && issue_warp == 5'd0, "R5", "lowest eligible chosen", issue_warp, 0);
            chk(issue_pc == 8'(i) && issue_blk == 8'h11, "R8", "index advance",
                issue_pc, i);
            chk(issue_lanes == 32'hFFFF_FFFF, "R2", "full warp mask", issue_lanes, 32'hFFFF_FFFF);
            if (i > 0) chk(at - last_at == 4, "R6", "issue spacing", at - last_at, 4);
            last_at = at;
        end

        // switch warps: change eligibility inside the window
        warp_ready = 24'h6;
        wait_issue(8, got, at);
        chk(got && issue_warp == 5'd1 && issue_pc == 8'd0, "R5", "warp1 first issue",
            issue_warp, 1);
        last_at = at;
        warp_ready = 24'h4;
        wait_issue(8, got, at);
        chk(got && issue_warp == 5'd2, "R7", "switched warp", issue_warp, 2);
        chk(at - last_at == 4, "R7", "no switch penalty", at - last_at, 4);
        last_at = at;
        // pulse eligibility of warp0 only inside the window: must not issue it
        @(negedge clk);
        warp_ready = 24'h1;
        @(negedge clk);
        warp_ready = 24'h0;
        wait_issue(10, got, at);
        chk(got == 1'b0, "R6", "eligibility inside window ignored", got, 0);

        // nothing eligible, or ready only on an empty slot
        warp_ready = 24'h20;
        wait_issue(12, got, at);
        chk(got == 1'b0, "R4", "no issue from empty slot", got, 0);

        // completions: free slot 0, spurious completion of empty slot 10
        complete(0);
        complete(10);
        warp_ready = 24'h7;
        wait_issue(8, got, at);
        chk(got && issue_warp == 5'd1 && issue_pc == 8'd1, "R9", "slot0 released",
            {issue_warp, issue_pc}, {5'd1, 8'd1});
        warp_ready = '0;
        repeat (4) @(negedge clk);
        launch(8'h22, 32, rdy);
        chk(rdy == 1'b1, "R1", "reuse lowest slot", rdy, 1);
        launch(8'h33, 512, rdy);
        chk(rdy == 1'b1, "R1", "16-warp block", rdy, 1);
        launch(8'h44, 192, rdy);
        chk(rdy == 1'b0, "R3", "too few free slots", rdy, 0);
        launch(8'h55, 160, rdy);
        chk(rdy == 1'b1, "R9", "empty-slot completion ignored: 5 fit", rdy, 1);
        warp_ready = 24'h80_0000;
        wait_issue(8, got, at);
        chk(got && issue_warp == 5'd23 && issue_blk == 8'h55, "R1", "top slot holds last block",
            {issue_warp, issue_blk}, {5'd23, 8'h55});
        warp_ready = 24'h1;
        wait_issue(8, got, at);
        chk(got && issue_blk == 8'h22 && issue_pc == 8'd0, "R8", "reused slot index restarts",
            {issue_blk, issue_pc}, {8'h22, 8'd0});
        warp_ready = '0;

        // block limit
        do_reset();
        for (int b = 0; b < 8; b++) begin
            launch(8'(b), 1, rdy);
            chk(rdy == 1'b1, "R3", "block under limit", rdy, 1);
        end
        launch(8'h99, 1, rdy);
        chk(rdy == 1'b0, "R3", "ninth block refused", rdy, 0);
        complete(3);
        launch(8'h99, 33, rdy);
        chk(rdy == 1'b1, "R9", "retired block frees place", rdy, 1);
        warp_ready = 24'h100;
        wait_issue(8, got, at);
        chk(got && issue_warp == 5'd8 && issue_lanes == 32'h1, "R2", "second warp tail",
            {issue_warp, issue_lanes}, {5'd8, 32'h1});
        warp_ready = 24'h8;
        wait_issue(8, got, at);
        chk(got && issue_warp == 5'd3 && issue_blk == 8'h99, "R1", "first warp in freed slot",
            issue_warp, 3);
        warp_ready = '0;

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule